// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs single-master external bus cycles for a 16-bit processor core with a 20-bit physical address space. An internal requester presents a transfer: address, direction, memory or I/O space, byte or word width and, for writes, the data. The controller then sequences one cycle on a shared set of pins. The low sixteen lines carry first the address and then the data. An address latch enable pulse marks the address. Four upper lines carry the top address bits and then a status code. A byte-high enable works with address bit 0 to select the byte lanes. Active-low read and write strobes, a data enable and a direction signal steer external transceivers.

A slow memory or device stretches the cycle by holding the ready input low. When the cycle ends, the controller returns read data aligned to bit 0 and pulses a done flag. The controller takes a new request in the last state of a cycle, so back-to-back transfers leave no idle gap.

Top module: `adbus_ctrl`

## Requirements
- R1: While reset is held (asynchronous, active low), and at any time with no cycle in progress, the controller behaves as idle. In this state `ad_oe_o`=0, `ale_o`=0, `rd_no`=`wr_no`=`den_no`=1, `dtr_o`=0, `mio_o`=0 and `as_o`=0.
- R2: In the first state after a request is accepted (T1), `ale_o`=1 for exactly one cycle and the controller drives the bus. `ad_o` carries address bits 15..0, with bit 0 forced to 0 for a word request. `as_o` carries address bits 19..16, `mio_o` is 1 for memory and 0 for I/O, and `dtr_o` is 1 for a write.
- R3: In T1, the pair {`bhe_no`, `ad_o[0]`} selects the lanes. A word gives 0,0. A byte at an odd address gives 0,1. A byte at an even address gives 1,0.
- R4: From the state after T1 to the end of the cycle, `as_o` carries status: bits 3 and 2 are 0, bit 1 is the I/O flag and bit 0 is the write flag. During this phase `bhe_no` is held at 1.
- R5: The strobe is low from T2 through the last T3 state and high in T4. A read uses `rd_no` and a write uses `wr_no`. The two strobes are never low together.
- R6: T3 repeats for every clock edge at which `ready_i` is sampled low in T3. A zero-wait cycle lasts exactly four states, T1 to T4. `done_o` never rises before `ready_i` has been sampled high.
- R7: On a write, `den_no`=0 and the bus carries the write data from T2 through T4. A word puts all 16 bits on the bus. An even byte puts `req_wdata_i[7:0]` on bits 7..0, and an odd byte puts it on bits 15..8. The unused lane is zero.
- R8: On a read, the controller stops driving the bus from T2 onward. `den_no`=0 from T2 through the last T3. The bus is captured at the edge that ends the last T3. An odd byte is shifted down to bits 7..0, and the upper byte of any byte result is zero.
- R9: `done_o` is high for exactly one cycle, in T4. For a read, `rdata_o` is valid in that cycle. `rdata_o` holds its value until the next read completes, and writes leave it unchanged.
- R10: A request is taken only when `req_ready_o`=1, which means idle or T4. A request in T4 starts T1 on the next cycle. Requests and input changes made while `req_ready_o`=0 have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr_i | input | 20 | Physical address |
| req_wdata_i | input | 16 | Write data (byte in bits 7..0) |
| req_ready_o | output | 1 | Request can be taken this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Aligned read data |
| ready_i | input | 1 | Wait-state control from the slave |
| ad_i | input | 16 | Shared bus, input side |
| ad_o | output | 16 | Shared bus, output side |
| ad_oe_o | output | 1 | Shared bus drive enable |
| as_o | output | 4 | Upper address, then status |
| ale_o | output | 1 | Address latch enable |
| bhe_no | output | 1 | High byte enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| den_no | output | 1 | Data transceiver enable, active low |
| dtr_o | output | 1 | Direction: 1 transmit, 0 receive |
| mio_o | output | 1 | 1 memory, 0 I/O |

## Verification
The bench uses the default widths: a 20-bit address and a 16-bit bus. This leaves four shared upper lines and two 8-bit lanes, so every lane encoding can be reached with concrete values. These include an odd word address, for which bit 0 must be forced low, and odd and even bytes in both directions. Wait counts of zero to three reach the repeated T3 path. A request presented in T4 covers the gapless chaining. A request presented mid-cycle, and reset asserted while a write strobe is active, cover the two ways a cycle can be disturbed.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ready_i,
  output bus_st_e st_o,
  output logic    accept_o,
  output logic    can_take_o,
  output logic    capture_o
);
  bus_st_e st_q, st_d;

  assign can_take_o = (st_q == ST_IDLE) || (st_q == ST_T4);
  assign accept_o   = req_i && can_take_o;
  assign capture_o  = (st_q == ST_T3) && ready_i;
  assign st_o       = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   if (ready_i) st_d = ST_T4;
      ST_T4:   st_d = accept_o ? ST_T1 : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/adbus_lane.sv
module adbus_lane #(
  parameter int unsigned DW = 16
) (
  input  logic          word_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic          bhe_n_o,
  output logic          a0_o,
  output logic [DW-1:0] wbus_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HW = DW / 2;

  assign bhe_n_o = !word_i && !a0_i;
  assign a0_o    = word_i ? 1'b0 : a0_i;

  always_comb begin
    if (word_i)    wbus_o = wdata_i;
    else if (a0_i) wbus_o = {wdata_i[HW-1:0], {HW{1'b0}}};
    else           wbus_o = {{HW{1'b0}}, wdata_i[HW-1:0]};
  end

  always_comb begin
    if (word_i)    rdata_o = bus_i;
    else if (a0_i) rdata_o = {{HW{1'b0}}, bus_i[DW-1:HW]};
    else           rdata_o = {{HW{1'b0}}, bus_i[HW-1:0]};
  end
endmodule

// File: rtl/adbus_pins.sv
module adbus_pins
  import adbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  bus_st_e          st_i,
  input  logic             write_i,
  input  logic             io_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             a0_i,
  input  logic             bhe_n_i,
  input  logic [DW-1:0]    wbus_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] as_o,
  output logic             ale_o,
  output logic             bhe_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic             den_no,
  output logic             dtr_o,
  output logic             mio_o
);
  localparam int unsigned UW = AW - DW;

  logic [UW-1:0] status;
  always_comb begin
    status    = '0;
    status[1] = io_i;
    status[0] = write_i;
  end

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    as_o    = '0;
    ale_o   = 1'b0;
    bhe_no  = 1'b1;
    rd_no   = 1'b1;
    wr_no   = 1'b1;
    den_no  = 1'b1;
    dtr_o   = 1'b0;
    mio_o   = 1'b0;
    unique case (st_i)
      ST_T1: begin
        ale_o   = 1'b1;
        ad_oe_o = 1'b1;
        ad_o    = {addr_i[DW-1:1], a0_i};
        as_o    = addr_i[AW-1:DW];
        bhe_no  = bhe_n_i;
        mio_o   = !io_i;
        dtr_o   = write_i;
      end
      ST_T2, ST_T3: begin
        as_o   = status;
        mio_o  = !io_i;
        dtr_o  = write_i;
        den_no = 1'b0;
        if (write_i) begin
          wr_no   = 1'b0;
          ad_oe_o = 1'b1;
          ad_o    = wbus_i;
        end else begin
          rd_no = 1'b0;
        end
      end
      ST_T4: begin
        as_o  = status;
        mio_o = !io_i;
        dtr_o = write_i;
        if (write_i) begin
          den_no  = 1'b0;
          ad_oe_o = 1'b1;
          ad_o    = wbus_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic             req_io_i,
  input  logic             req_word_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  input  logic             ready_i,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] as_o,
  output logic             ale_o,
  output logic             bhe_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic             den_no,
  output logic             dtr_o,
  output logic             mio_o
);
  bus_st_e       st;
  logic          accept, capture;
  logic          write_q, io_q, word_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          bhe_n, a0;
  logic [DW-1:0] wbus, rd_aligned;

  adbus_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ready_i    (ready_i),
    .st_o       (st),
    .accept_o   (accept),
    .can_take_o (req_ready_o),
    .capture_o  (capture)
  );

  // request is frozen at acceptance; pins never see live inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      io_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      io_q    <= req_io_i;
      word_q  <= req_word_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  adbus_lane #(.DW(DW)) u_lane (
    .word_i  (word_q),
    .a0_i    (addr_q[0]),
    .wdata_i (wdata_q),
    .bus_i   (ad_i),
    .bhe_n_o (bhe_n),
    .a0_o    (a0),
    .wbus_o  (wbus),
    .rdata_o (rd_aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if (capture && !write_q) rdata_q <= rd_aligned;
  end

  assign rdata_o = rdata_q;
  assign done_o  = (st == ST_T4);

  adbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .st_i    (st),
    .write_i (write_q),
    .io_i    (io_q),
    .addr_i  (addr_q),
    .a0_i    (a0),
    .bhe_n_i (bhe_n),
    .wbus_i  (wbus),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .as_o    (as_o),
    .ale_o   (ale_o),
    .bhe_no  (bhe_no),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .den_no  (den_no),
    .dtr_o   (dtr_o),
    .mio_o   (mio_o)
  );
endmodule

// File: rtl/adbus_ctrl_chk.sv
module adbus_ctrl_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          req_ready_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic          ready_i,
  input logic          ad_oe_o,
  input logic          ale_o,
  input logic          bhe_no,
  input logic          rd_no,
  input logic          wr_no,
  input logic          den_no
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !done_o) |-> (!ad_oe_o && !ale_o && rd_no && wr_no && den_no));

  assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_ale_addr_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && rd_no && wr_no && den_no));

  assert_s7_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> bhe_no);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));

  assert_ready_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ready_i));

  assert_no_fight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);

  assert_accept_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> $past(req_i && req_ready_o));
endmodule

bind adbus_ctrl adbus_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .ready_i     (ready_i),
  .ad_oe_o     (ad_oe_o),
  .ale_o       (ale_o),
  .bhe_no      (bhe_no),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .den_no      (den_no)
);

// File: tb/sim_adbus_ctrl.sv
`timescale 1ns/1ps
module sim_adbus_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0, req_io_i = 1'b0, req_word_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_ready_o, done_o;
  logic [15:0] rdata_o;
  logic        ready_i = 1'b0;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic        ad_oe_o;
  logic [3:0]  as_o;
  logic        ale_o, bhe_no, rd_no, wr_no, den_no, dtr_o, mio_o;

  always #2.5 clk_i = ~clk_i;

  adbus_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
    .req_io_i(req_io_i), .req_word_i(req_word_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o), .done_o(done_o),
    .rdata_o(rdata_o), .ready_i(ready_i), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .as_o(as_o), .ale_o(ale_o), .bhe_no(bhe_no),
    .rd_no(rd_no), .wr_no(wr_no), .den_no(den_no), .dtr_o(dtr_o), .mio_o(mio_o)
  );

  typedef struct packed {
    logic        wr;
    logic        io;
    logic        word;
    logic [3:0]  waits;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [15:0] bus;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'd0, 20'hA1234, 16'h0000, 16'hBEEF, 16'hBEEF},
    '{1'b0, 1'b0, 1'b0, 4'd2, 20'h00101, 16'h0000, 16'h5AC3, 16'h005A},
    '{1'b0, 1'b1, 1'b0, 4'd0, 20'h00042, 16'h0000, 16'h77E1, 16'h00E1},
    '{1'b1, 1'b0, 1'b1, 4'd1, 20'hF0010, 16'hCAFE, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 4'd0, 20'h003F9, 16'h12AB, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 4'd3, 20'h56788, 16'h3C96, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 4'd1, 20'h7FFFF, 16'h0000, 16'h0F0F, 16'h0F0F},
    '{1'b0, 1'b0, 1'b0, 4'd0, 20'h80000, 16'h0000, 16'h1234, 16'h0034}
  };

  int nchk = 0, nfail = 0;
  logic [15:0] last_rd = 16'h0000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(!ad_oe_o && !ale_o && rd_no && wr_no && den_no && !dtr_o && !mio_o && as_o == 4'h0,
        tag, {ad_oe_o, ale_o, rd_no, wr_no, den_no, dtr_o, mio_o, as_o},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0});
  endtask

  task automatic chk_mid(input vec_t v, input logic [15:0] exp_w);
    logic [3:0] st = {2'b00, v.io, v.wr};
    chk(!ale_o && as_o == st && bhe_no, "R4 status phase", {ale_o, as_o, bhe_no}, {1'b0, st, 1'b1});
    if (v.wr) chk(!wr_no && rd_no, "R5 write strobe", {rd_no, wr_no}, 2'b10);
    else      chk(!rd_no && wr_no, "R5 read strobe", {rd_no, wr_no}, 2'b01);
    if (v.wr) chk(!den_no && dtr_o && ad_oe_o && ad_o == exp_w, "R7 write data",
                  {den_no, dtr_o, ad_oe_o, ad_o}, {1'b0, 1'b1, 1'b1, exp_w});
    else      chk(!den_no && !dtr_o && !ad_oe_o, "R8 bus released",
                  {den_no, dtr_o, ad_oe_o}, 3'b000);
  endtask

  // call at a negedge; returns at the negedge inside T4
  task automatic run_vec(input vec_t v, input bit poke);
    logic [15:0] exp_ad, exp_w;
    logic        exp_bhe;
    exp_ad  = v.word ? {v.addr[15:1], 1'b0} : v.addr[15:0];
    exp_bhe = v.word ? 1'b0 : !v.addr[0];
    exp_w   = v.word ? v.wdata : (v.addr[0] ? {v.wdata[7:0], 8'h00} : {8'h00, v.wdata[7:0]});
    req_write_i = v.wr; req_io_i = v.io; req_word_i = v.word;
    req_addr_i = v.addr; req_wdata_i = v.wdata; req_i = 1'b1;
    ad_i = v.bus; ready_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    // T1
    chk(ale_o && ad_oe_o, "R2 latch pulse and drive", {ale_o, ad_oe_o}, 2'b11);
    chk(ad_o == exp_ad, "R2 low address", ad_o, exp_ad);
    chk(as_o == v.addr[19:16] && mio_o == !v.io && dtr_o == v.wr, "R2 upper/space/dir",
        {as_o, mio_o, dtr_o}, {v.addr[19:16], !v.io, v.wr});
    chk(bhe_no == exp_bhe && ad_o[0] == exp_ad[0], "R3 lane code",
        {bhe_no, ad_o[0]}, {exp_bhe, exp_ad[0]});
    chk(!req_ready_o, "R10 busy in T1", req_ready_o, 0);
    // T2
    @(negedge clk_i);
    chk_mid(v, exp_w);
    if (poke) begin
      req_i = 1'b1; req_addr_i = 20'h12345; req_write_i = !v.wr;
      req_word_i = !v.word; req_wdata_i = 16'hDEAD;
    end
    // T3 and waits
    for (int k = 0; k <= int'(v.waits); k++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      chk_mid(v, exp_w);
      chk(!done_o, "R6 no done while waiting", done_o, 0);
      ready_i = (k == int'(v.waits));
    end
    // T4
    @(negedge clk_i);
    ready_i = 1'b0;
    chk(done_o, "R9 done in T4", done_o, 1);
    chk(rd_no && wr_no, "R5 strobes off in T4", {rd_no, wr_no}, 2'b11);
    chk(req_ready_o, "R10 ready in T4", req_ready_o, 1);
    if (v.wr) begin
      chk(!den_no && ad_oe_o && ad_o == exp_w, "R7 write held in T4",
          {den_no, ad_oe_o, ad_o}, {1'b0, 1'b1, exp_w});
      chk(rdata_o == last_rd, "R9 read data kept over write", rdata_o, last_rd);
    end else begin
      chk(den_no && !ad_oe_o, "R8 released in T4", {den_no, ad_oe_o}, 2'b10);
      chk(rdata_o == v.exp_rd, "R8 aligned read data", rdata_o, v.exp_rd);
      last_rd = v.exp_rd;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    nfail++;
    $display("FAIL R6 watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1 outputs in reset");
    chk(!done_o && rdata_o == 16'h0, "R9 reset result", {done_o, rdata_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 idle after reset");
    chk(req_ready_o, "R10 ready when idle", req_ready_o, 1);

    // table walk; vector 1 receives a request while busy
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i == 1);
      @(negedge clk_i);
      chk_idle("R1 idle between cycles");
      chk(!done_o, "R9 single done pulse", done_o, 0);
      @(negedge clk_i);
      chk(!ale_o, "R10 busy request not taken", ale_o, 0);
    end

    // chaining: second request issued in T4 of the first
    run_vec(VECS[3], 1'b0);
    run_vec(VECS[2], 1'b0);
    @(negedge clk_i);
    chk_idle("R1 idle after chained pair");

    // reset while the write strobe is active
    req_write_i = 1'b1; req_io_i = 1'b0; req_word_i = 1'b1;
    req_addr_i = 20'h00200; req_wdata_i = 16'hA5A5; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    chk(!wr_no, "R5 strobe before reset", wr_no, 0);
    #1 rst_ni = 1'b0;
    #0.5 chk_idle("R1 async reset mid-cycle");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 idle after mid-cycle reset");
    chk(req_ready_o && !done_o && rdata_o == 16'h0, "R9 no completion after reset",
        {req_ready_o, done_o, rdata_o}, {1'b1, 1'b0, 16'h0});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule